// File: doc/BRIEF.md
# Scanline Match Interrupt Controller

This block raises a level interrupt toward the CPU when the video pipeline reports a scanline whose number equals a line programmed by software. A strobe arrives once per scanline with the current line number and a vertical-blank indication. When the line matches the programmed target and the strobe falls outside vertical blank, the whole status byte is set to all ones. This marks the interrupt as pending.

Software programs the target line and an enable bit through a small register write port. It reads the status byte through a read port, and that read clears the pending bit as a side effect. A second bit of the status byte follows whether rendering is inside the visible frame. An interrupt request from the audio unit is registered and merged into the same output line. A separate debug port shows the status byte at all times, without the clearing side effect.

Top module: `scanline_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the target line is 0, the enable bit is 0, the status byte is 0x00, the audio flag is 0 and `irq_out` is low.
- R2: A scanline strobe with `in_vblank` low and `line_num` equal to the target line sets the status byte to 0xFF (bit 7 = pending) on that clock edge.
- R3: A strobe during vertical blank, a strobe with a different line number, or a cycle without a strobe never sets the pending bit. A target of 0 does not match while `in_vblank` is high.
- R4: A write to address 1 loads bit 7 of `wr_data` into the enable bit and ignores bits 6..0. Reading address 1 returns the enable in bit 7 and zeros elsewhere.
- R5: Reading address 2 returns the status byte as it was before the edge, then clears only bit 7. If a match occurs in the same cycle as the read, the match wins and the status becomes 0xFF.
- R6: Status bit 6 (in-frame) is cleared on any edge where `in_vblank` is high. It is set by a strobe with `in_vblank` low.
- R7: `aud_irq_in` is latched into the audio flag on every edge. The flag drives `irq_out` whatever the enable bit is.
- R8: `irq_out` is a level equal to (pending AND enable) OR audio flag, all taken from registered state. It falls after the read that clears the pending bit.
- R9: `dbg_status` always shows the status byte, and observing it never changes state.
- R10: A write to address 0 loads the target line, and a read of address 0 returns it. Address 3 reads as 0x00. A write takes effect from the next edge, so a match in the same cycle uses the old target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pulse | input | 1 | One-cycle strobe per scanline |
| line_num | input | 8 | Current scanline number, valid with the strobe |
| in_vblank | input | 1 | High while outside the visible frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 target, 1 enable |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; a read of address 2 clears pending |
| rd_addr | input | 2 | Read address: 0 target, 1 enable, 2 status |
| rd_data | output | 8 | Read data, valid in the cycle of `rd_en` |
| dbg_status | output | 8 | Status byte, readable without side effects |
| aud_irq_in | input | 1 | Interrupt request from the audio unit |
| irq_out | output | 1 | Merged level interrupt |

## Verification
Directed cases try strobes at the target line outside blank, at the target line inside blank (including target 0), and at neighbouring lines. These separate a correct line compare from one that ignores blank or compares off by one. Reads of the status register are tried alone and in the same cycle as a match, which shows whether clear or set takes priority and whether the clear leaves bits 6..0 alone. Random sequences mix strobes near the target, register writes with random spare bits, and audio request toggles. They show whether the enable gating, the audio path and the in-frame flag stay apart in the merged output.

// File: rtl/sli_pkg.sv
// Shared constants for the scanline match interrupt controller.
// Assumes an 8-bit status byte and a 2-bit register address space.
package sli_pkg;
    localparam int REG_ADDR_W = 2;
    localparam logic [REG_ADDR_W-1:0] ADDR_TARGET = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_ENABLE = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd2;
endpackage

// File: rtl/sli_cfg_regs.sv
// Configuration registers: target line and interrupt enable.
// Assumes LINE_W <= DATA_W; the enable is taken from the top data bit.
module sli_cfg_regs
    import sli_pkg::*;
#(
    parameter int LINE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [LINE_W-1:0]     target,
    output logic                  enable
);
    localparam int EN_BIT = DATA_W - 1;

    // Load target line or enable bit on a CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
            enable <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_TARGET) target <= wr_data[LINE_W-1:0];
            if (wr_addr == ADDR_ENABLE) enable <= wr_data[EN_BIT];
        end
    end
endmodule

// File: rtl/sli_status_unit.sv
// Status byte: line compare, pending flag, in-frame flag, read clear.
// Assumes a match only counts outside vertical blank; a match beats a clear.
module sli_status_unit #(
    parameter int LINE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              in_vblank,
    input  logic [LINE_W-1:0] target,
    input  logic              clr_pending,
    output logic [DATA_W-1:0] status
);
    localparam int PEND_BIT  = DATA_W - 1;
    localparam int FRAME_BIT = DATA_W - 2;

    logic hit;

    // Decide whether this strobe hits the programmed line.
    always_comb begin
        hit = line_pulse && !in_vblank && (line_num == target);
    end

    // Update the status byte: set on hit, otherwise track frame and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (hit) begin
            status <= '1;
        end else begin
            if (in_vblank)       status[FRAME_BIT] <= 1'b0;
            else if (line_pulse) status[FRAME_BIT] <= 1'b1;
            if (clr_pending)     status[PEND_BIT]  <= 1'b0;
        end
    end
endmodule

// File: rtl/sli_irq_merge.sv
// Latches the audio request and merges it with the scanline interrupt.
// Assumes all inputs are registered state, so the output is glitch free.
module sli_irq_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic aud_req,
    input  logic pending,
    input  logic enable,
    output logic aud_flag,
    output logic irq
);
    // Capture the audio request level each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) aud_flag <= 1'b0;
        else        aud_flag <= aud_req;
    end

    // Form the merged level interrupt.
    always_comb begin
        irq = (pending && enable) || aud_flag;
    end
endmodule

// File: rtl/scanline_irq_ctrl.sv
// Top: scanline match interrupt controller with a CPU register port,
// a side-effect-free debug view of status, and an audio interrupt merge.
// Assumes single-cycle rd_en / wr_en strobes and synchronous reset.
module scanline_irq_ctrl
    import sli_pkg::*;
#(
    parameter int LINE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_pulse,
    input  logic [LINE_W-1:0]     line_num,
    input  logic                  in_vblank,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic [DATA_W-1:0]     dbg_status,
    input  logic                  aud_irq_in,
    output logic                  irq_out
);
    localparam int PEND_BIT = DATA_W - 1;

    logic [LINE_W-1:0] target_q;
    logic              enable_q;
    logic [DATA_W-1:0] status_q;
    logic              aud_flag_q;
    logic              clr_pending;

    // A status read strobe clears the pending bit at the next edge.
    always_comb begin
        clr_pending = rd_en && (rd_addr == ADDR_STATUS);
    end

    sli_cfg_regs #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .target  (target_q),
        .enable  (enable_q)
    );

    sli_status_unit #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_pulse  (line_pulse),
        .line_num    (line_num),
        .in_vblank   (in_vblank),
        .target      (target_q),
        .clr_pending (clr_pending),
        .status      (status_q)
    );

    sli_irq_merge u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .aud_req  (aud_irq_in),
        .pending  (status_q[PEND_BIT]),
        .enable   (enable_q),
        .aud_flag (aud_flag_q),
        .irq      (irq_out)
    );

    // Read multiplexer: returns pre-edge register values.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (rd_addr)
                ADDR_TARGET: rd_data[LINE_W-1:0] = target_q;
                ADDR_ENABLE: rd_data[PEND_BIT]   = enable_q;
                ADDR_STATUS: rd_data             = status_q;
                default:     rd_data             = '0;
            endcase
        end
    end

    // Debug view of status without side effects.
    always_comb begin
        dbg_status = status_q;
    end
endmodule

// File: rtl/sli_checker.sv
// Assertion checker for scanline_irq_ctrl, attached by bind.
module sli_checker
    import sli_pkg::*;
#(
    parameter int LINE_W = 8,
    parameter int DATA_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  line_pulse,
    input logic [LINE_W-1:0]     line_num,
    input logic                  in_vblank,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic                  rd_en,
    input logic [REG_ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0]     dbg_status,
    input logic                  aud_irq_in,
    input logic                  irq_out,
    input logic [LINE_W-1:0]     target_q,
    input logic                  enable_q,
    input logic                  aud_flag_q
);
    localparam int PB = DATA_W - 1;
    localparam int FB = DATA_W - 2;

    // R2
    match_sets_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && !in_vblank && line_num == target_q) |=> (dbg_status == {DATA_W{1'b1}}));

    // R3
    no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_pulse && !dbg_status[PB]) |=> !dbg_status[PB]);

    // R4
    enable_bit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_ENABLE) |=> (enable_q == $past(wr_data[PB])));

    // R5
    read_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_STATUS && !line_pulse) |=> !dbg_status[PB]);

    // R6
    vblank_clears_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vblank |=> !dbg_status[FB]);

    // R7
    audio_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aud_irq_in |=> irq_out);

    // R8
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((dbg_status[PB] && enable_q) || aud_flag_q));
endmodule

bind scanline_irq_ctrl sli_checker #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_sli_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_pulse (line_pulse),
    .line_num   (line_num),
    .in_vblank  (in_vblank),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .dbg_status (dbg_status),
    .aud_irq_in (aud_irq_in),
    .irq_out    (irq_out),
    .target_q   (target_q),
    .enable_q   (enable_q),
    .aud_flag_q (aud_flag_q)
);

// File: tb/test_scanline_irq_ctrl.sv
module test_scanline_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_pulse = 1'b0;
    logic [7:0] line_num = '0;
    logic       in_vblank = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] dbg_status;
    logic       aud_irq_in = 1'b0;
    logic       irq_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // bench model of the registers
    logic [7:0] m_target = '0;
    logic       m_en = 1'b0;
    logic [7:0] m_stat = '0;
    logic       m_aud = 1'b0;

    scanline_irq_ctrl i_scanline_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .line_num(line_num),
        .in_vblank(in_vblank), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .dbg_status(dbg_status),
        .aud_irq_in(aud_irq_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_target;
            2'd1: return {m_en, 7'b0};
            2'd2: return m_stat;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_stat[7] && m_en) || m_aud;
    endfunction

    // One clock: drive at negedge, check read, advance model, check state.
    task automatic step(input bit p, input logic [7:0] ln, input bit vb,
                        input bit w, input logic [1:0] wa, input logic [7:0] wd,
                        input bit r, input logic [1:0] ra, input bit aud,
                        input string req);
        logic hit;
        line_pulse = p; line_num = ln; in_vblank = vb;
        wr_en = w; wr_addr = wa; wr_data = wd;
        rd_en = r; rd_addr = ra; aud_irq_in = aud;
        #1;
        if (r) check(rd_data == exp_read(ra), req, "rd_data", rd_data, exp_read(ra));
        @(posedge clk);
        hit = p && !vb && (ln == m_target);
        if (hit) m_stat = 8'hFF;
        else begin
            if (vb) m_stat[6] = 1'b0;
            else if (p) m_stat[6] = 1'b1;
            if (r && ra == 2'd2) m_stat[7] = 1'b0;
        end
        if (w && wa == 2'd0) m_target = wd;
        if (w && wa == 2'd1) m_en = wd[7];
        m_aud = aud;
        @(negedge clk);
        line_pulse = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        check(dbg_status == m_stat, req, "dbg_status", dbg_status, m_stat);
        check(irq_out == exp_irq(), "R8", "irq_out", irq_out, exp_irq());
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(dbg_status == 8'h00, "R1", "status after reset", dbg_status, 0);
        check(irq_out == 1'b0, "R1", "irq after reset", irq_out, 0);
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 1, 2'd1, 0, "R1");
        // R10: target write/read back, address 3 reads zero
        step(0, 0, 0, 1, 2'd0, 8'd37, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 1, 2'd3, 0, "R10");
        // R4: spare bits ignored
        step(0, 0, 0, 1, 2'd1, 8'h7F, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, 1, 2'd1, 0, "R4");
        step(0, 0, 0, 1, 2'd1, 8'h80, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, 1, 2'd1, 0, "R4");
        // R6 / R3: neighbour line sets in-frame only
        step(1, 8'd36, 0, 0, 0, 0, 0, 0, 0, "R6");
        step(1, 8'd38, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 8'd37, 1, 0, 0, 0, 0, 0, 0, "R3");
        // R2: match
        step(1, 8'd37, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R9: debug view does not clear
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        // R5: status read clears bit 7 only
        step(0, 0, 0, 0, 0, 0, 1, 2'd2, 0, "R5");
        step(0, 0, 0, 0, 0, 0, 1, 2'd2, 0, "R5");
        // R8: disabled match keeps irq low
        step(0, 0, 0, 1, 2'd1, 8'h00, 0, 0, 0, "R8");
        step(1, 8'd37, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 2'd1, 8'h80, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 1, 2'd2, 0, "R8");
        // R7: audio flag independent of enable
        step(0, 0, 0, 1, 2'd1, 8'h00, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R6: vblank clears in-frame
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R6");
        // R3: target 0 during vblank never matches
        step(0, 0, 0, 1, 2'd0, 8'd0, 1, 2'd2, 0, "R3");
        step(1, 8'd0, 1, 0, 0, 0, 0, 0, 0, "R3");
        // R5: read and match in the same cycle, match wins
        step(1, 8'd0, 0, 0, 0, 0, 1, 2'd2, 0, "R5");
        // R10: write and match same cycle uses old target
        step(1, 8'd0, 0, 1, 2'd0, 8'd9, 1, 2'd2, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 1, 2'd2, 0, "R10");
        step(1, 8'd0, 0, 0, 0, 0, 0, 0, 0, "R10");
        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [7:0] ln;
            op = $urandom_range(0, 9);
            ln = ($urandom_range(0, 2) == 0) ? 8'($urandom) : m_target + 8'($urandom_range(0, 2)) - 8'd1;
            if (op < 4)
                step(1, ln, $urandom_range(0, 3) == 0, 0, 0, 0, $urandom_range(0, 5) == 0, 2'd2,
                     $urandom_range(0, 7) == 0, "R2");
            else if (op < 6)
                step(0, 0, $urandom_range(0, 1) == 1, 0, 0, 0, 1, 2'($urandom), $urandom_range(0, 7) == 0, "R5");
            else if (op < 8)
                step(0, 0, 0, 1, 2'($urandom), 8'($urandom), 0, 0, $urandom_range(0, 7) == 0, "R4");
            else
                step(0, 0, $urandom_range(0, 1) == 1, 0, 0, 0, 0, 0, $urandom_range(0, 1) == 1, "R7");
        end
        // R1: reset in the middle clears everything
        step(1, m_target, 0, 1, 2'd1, 8'h80, 0, 0, 1, "R1");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        aud_irq_in = 1'b0;
        rst_n = 1'b1;
        m_target = '0; m_en = 1'b0; m_stat = '0; m_aud = 1'b0;
        check(dbg_status == 8'h00, "R1", "status after re-reset", dbg_status, 0);
        check(irq_out == 1'b0, "R1", "irq after re-reset", irq_out, 0);
        step(0, 0, 0, 0, 0, 0, 1, 2'd0, 0, "R1");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule